// File: doc/BRIEF.md
# Memory Barrier Ordering Gate

The gate sits between an in-order issue stream and a memory request port. Each cycle the stream presents at most one instruction: a load, a store or a barrier. Loads and stores that are allowed through appear on the request port in the same cycle. The gate counts them as outstanding until the memory side acknowledges them. It keeps one load counter and one store counter for each of three shareability levels: inner, outer and system.

A barrier names a level, a type qualifier and a flavour. The level decides which outstanding accesses the barrier waits on. A barrier at a given level covers accesses of that level and of every narrower level. The type qualifier picks which earlier access kinds are waited on and which later access kinds are held back. An ordering barrier is accepted at once, and only the later accesses of the held-back kinds stall until the awaited counters drain. A completion barrier holds the whole issue stream until the awaited counters drain.

A barrier that finds nothing to wait for retires in the cycle it is presented and leaves no state behind. Acknowledgements carry their own level, so the memory side may return them in any order across levels.

Top module: `mem_barrier_gate`

## Requirements
- R1: After reset no barrier is pending and every counter is zero, so `stall` is low and a barrier presented next retires without stalling.
- R2: A load or store that is not stalled appears on the request port in the same cycle, with `mem_req_addr` and `mem_req_dom` equal to its issue fields. `mem_req_store` is 1 for a store.
- R3: The gate keeps an outstanding count per access kind and per level. The count rises by one on each issued access and falls by one on each acknowledgement. An acknowledgement that arrives when its count is zero is ignored. An access whose count is already at its maximum of 2^CNT_W-1 stalls.
- R4: `issue_kind` encodes 00 as load, 01 as store, and 10 or 11 as barrier. `issue_dom` (and each ack level) encodes 00 as inner, 01 as outer, and 10 or 11 as system. `issue_btype` encodes 00 as full, 01 as load, 10 as store, and 11 as full. `issue_sync` set to 1 marks a completion barrier.
- R5: A full barrier waits on outstanding loads and stores, and it holds back later loads and stores.
- R6: A load-qualified barrier waits only on outstanding loads, but it holds back both later loads and later stores.
- R7: A store-qualified barrier waits only on outstanding stores and holds back only later stores. Later loads pass freely.
- R8: A barrier at level L waits only on counters at levels up to L, ordered inner < outer < system.
- R9: An ordering barrier issues without a stall. While it waits, a later access of a held-back kind, or any later barrier, stalls. The stall drops in the cycle after the acknowledgement that empties the last awaited counter.
- R10: While a completion barrier waits, `stall` is high every cycle, whether or not `issue_valid` is set. It drops in the cycle after the last awaited acknowledgement.
- R11: A barrier whose awaited counters are all zero when it is presented retires in that same cycle and leaves no stall behind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | An instruction is presented |
| issue_kind | input | 2 | Instruction kind (load, store, barrier) |
| issue_dom | input | 2 | Access level, or barrier level |
| issue_btype | input | 2 | Barrier type qualifier |
| issue_sync | input | 1 | Barrier is a completion barrier |
| issue_addr | input | ADDR_W | Access address |
| ack_ld_valid | input | 1 | One load is acknowledged |
| ack_ld_dom | input | 2 | Level of the acknowledged load |
| ack_st_valid | input | 1 | One store is acknowledged |
| ack_st_dom | input | 2 | Level of the acknowledged store |
| stall | output | 1 | The presented instruction is not taken this cycle |
| mem_req_valid | output | 1 | A memory request is issued |
| mem_req_store | output | 1 | The request is a store |
| mem_req_dom | output | 2 | Level of the request |
| mem_req_addr | output | ADDR_W | Address of the request |

## Verification
The assertions check four things on every cycle. A request never goes out while `stall` is high, and only a load or store can produce one. No counter wraps from its maximum to zero. A pending completion barrier keeps `stall` high, and a barrier that meets empty counters with nothing pending is never stalled. The finer behaviour depends on the qualifier and the level: which kinds are held back, which levels a barrier ignores, and which cycle the release lands in. Only the bench shows these, through directed sequences and a long random run, checked every cycle against a behavioural model.

// File: rtl/mbg_pkg.sv
// Package: shared encodings and helpers for the memory barrier gate.
// Assumes three shareability levels; the encoding 2'b11 folds onto system.
package mbg_pkg;

    localparam int NUM_DOM = 3;

    localparam logic [1:0] KIND_LOAD  = 2'b00;
    localparam logic [1:0] KIND_STORE = 2'b01;

    localparam logic [1:0] BT_FULL  = 2'b00;
    localparam logic [1:0] BT_LOAD  = 2'b01;
    localparam logic [1:0] BT_STORE = 2'b10;

    // What a barrier waits on and what it holds back.
    typedef struct packed {
        logic wait_ld;
        logic wait_st;
        logic gate_ld;
        logic gate_st;
        logic gate_all;
    } bar_rule_t;

    // Fold a raw level code into an index 0..2.
    function automatic logic [1:0] dom_level(input logic [1:0] code);
        return (code == 2'b11) ? 2'd2 : code;
    endfunction

endpackage

// File: rtl/mbg_counter.sv
// Module: one outstanding-access counter.
// Counts up on an issued access and down on an acknowledgement. Increments
// at the maximum and decrements at zero are dropped. The parent is expected
// to stall before an increment at the maximum can be requested.
module mbg_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             zero,
    output logic             full
);
    localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

    logic inc_ok;
    logic dec_ok;

    // Flags and guarded step enables.
    always_comb begin
        zero   = (count == '0);
        full   = (count == MAXC);
        inc_ok = inc && !full;
        dec_ok = dec && !zero;
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count + CNT_W'(inc_ok) - CNT_W'(dec_ok);
        end
    end

endmodule

// File: rtl/mbg_barrier_decode.sv
// Module: turns a barrier's type qualifier and flavour into a rule.
// Purely combinational. Qualifier 2'b11 is treated as full.
module mbg_barrier_decode
    import mbg_pkg::*;
(
    input  logic [1:0] btype,
    input  logic       sync,
    output bar_rule_t  rule
);
    // Map the qualifier onto wait and hold-back masks.
    always_comb begin
        rule.gate_all = sync;
        case (btype)
            BT_LOAD: begin
                rule.wait_ld = 1'b1;
                rule.wait_st = 1'b0;
                rule.gate_ld = 1'b1;
                rule.gate_st = 1'b1;
            end
            BT_STORE: begin
                rule.wait_ld = 1'b0;
                rule.wait_st = 1'b1;
                rule.gate_ld = 1'b0;
                rule.gate_st = 1'b1;
            end
            default: begin
                rule.wait_ld = 1'b1;
                rule.wait_st = 1'b1;
                rule.gate_ld = 1'b1;
                rule.gate_st = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/mbg_drain_eval.sv
// Module: decides whether every counter a barrier waits on is empty.
// A barrier at a level covers that level and every narrower one.
// Assumes level index 0 is the narrowest.
module mbg_drain_eval #(
    parameter int NDOM = 3
) (
    input  logic [NDOM-1:0] ld_zero,
    input  logic [NDOM-1:0] st_zero,
    input  logic            wait_ld,
    input  logic            wait_st,
    input  logic [1:0]      level,
    output logic            drained
);
    logic [NDOM-1:0] lvl_ok;

    // One per level: out of scope, or every awaited count at zero.
    for (genvar d = 0; d < NDOM; d++) begin : g_lvl
        assign lvl_ok[d] = (2'(d) > level) ||
                           ((!wait_ld || ld_zero[d]) && (!wait_st || st_zero[d]));
    end

    assign drained = &lvl_ok;

endmodule

// File: rtl/mem_barrier_gate.sv
// Module: memory barrier ordering gate (top).
// Sits between an in-order issue stream and a memory request port. It counts
// outstanding loads and stores per level and applies barriers qualified by
// level, type and flavour. Assumes at most one instruction is presented per
// cycle and that a stalled instruction may be re-presented or dropped by the
// issue side. Acknowledgements use registered counts, so a release shows up
// in the cycle after the acknowledgement that empties the last counter.
module mem_barrier_gate
    import mbg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [1:0]        issue_kind,
    input  logic [1:0]        issue_dom,
    input  logic [1:0]        issue_btype,
    input  logic              issue_sync,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic              ack_ld_valid,
    input  logic [1:0]        ack_ld_dom,
    input  logic              ack_st_valid,
    input  logic [1:0]        ack_st_dom,
    output logic              stall,
    output logic              mem_req_valid,
    output logic              mem_req_store,
    output logic [1:0]        mem_req_dom,
    output logic [ADDR_W-1:0] mem_req_addr
);
    localparam int NDOM = NUM_DOM;

    logic                       is_ld, is_st, is_bar;
    logic [1:0]                 acc_lvl, ackl_lvl, acks_lvl;
    logic [NDOM-1:0]            dom_hit;
    logic [NDOM-1:0]            ld_zero, st_zero, ld_full, st_full;
    logic [NDOM-1:0][CNT_W-1:0] ld_cnt, st_cnt;
    bar_rule_t                  new_rule, pend_rule_q;
    logic [1:0]                 pend_lvl_q;
    logic                       pend_q;
    logic                       pend_drained, new_drained;
    logic                       blocking, saturated, held, bar_fire;

    // Instruction classification and level folding.
    always_comb begin
        is_ld    = issue_valid && (issue_kind == KIND_LOAD);
        is_st    = issue_valid && (issue_kind == KIND_STORE);
        is_bar   = issue_valid && issue_kind[1];
        acc_lvl  = dom_level(issue_dom);
        ackl_lvl = dom_level(ack_ld_dom);
        acks_lvl = dom_level(ack_st_dom);
    end

    // Outstanding counters, one load and one store counter per level.
    for (genvar d = 0; d < NDOM; d++) begin : g_dom
        assign dom_hit[d] = (acc_lvl == 2'(d));

        mbg_counter #(.CNT_W(CNT_W)) u_ld_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (mem_req_valid && is_ld && dom_hit[d]),
            .dec   (ack_ld_valid && (ackl_lvl == 2'(d))),
            .count (ld_cnt[d]),
            .zero  (ld_zero[d]),
            .full  (ld_full[d])
        );

        mbg_counter #(.CNT_W(CNT_W)) u_st_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (mem_req_valid && is_st && dom_hit[d]),
            .dec   (ack_st_valid && (acks_lvl == 2'(d))),
            .count (st_cnt[d]),
            .zero  (st_zero[d]),
            .full  (st_full[d])
        );
    end

    mbg_barrier_decode u_decode (
        .btype (issue_btype),
        .sync  (issue_sync),
        .rule  (new_rule)
    );

    mbg_drain_eval #(.NDOM(NDOM)) u_pend_drain (
        .ld_zero (ld_zero),
        .st_zero (st_zero),
        .wait_ld (pend_rule_q.wait_ld),
        .wait_st (pend_rule_q.wait_st),
        .level   (pend_lvl_q),
        .drained (pend_drained)
    );

    mbg_drain_eval #(.NDOM(NDOM)) u_new_drain (
        .ld_zero (ld_zero),
        .st_zero (st_zero),
        .wait_ld (new_rule.wait_ld),
        .wait_st (new_rule.wait_st),
        .level   (acc_lvl),
        .drained (new_drained)
    );

    // Stall decision for the presented instruction.
    always_comb begin
        blocking  = pend_q && !pend_drained;
        saturated = (is_ld && |(dom_hit & ld_full)) || (is_st && |(dom_hit & st_full));
        held      = blocking && ((is_ld && pend_rule_q.gate_ld) ||
                                 (is_st && pend_rule_q.gate_st) || is_bar);
        stall     = (blocking && pend_rule_q.gate_all) || held || saturated;
        bar_fire  = is_bar && !stall;
    end

    // Request port: accepted accesses pass straight through.
    always_comb begin
        mem_req_valid = (is_ld || is_st) && !stall;
        mem_req_store = issue_kind[0];
        mem_req_dom   = issue_dom;
        mem_req_addr  = issue_addr;
    end

    // Pending-barrier register: load on an undrained barrier, clear on drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_rule_q <= '0;
            pend_lvl_q  <= '0;
        end else if (bar_fire) begin
            pend_q      <= !new_drained;
            pend_rule_q <= new_rule;
            pend_lvl_q  <= acc_lvl;
        end else if (!blocking) begin
            pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/mbg_checker.sv
// Module: assertion checker for mem_barrier_gate, attached by bind.
// Observes ports plus the pending-barrier state and the counters.
module mbg_checker #(
    parameter int CNT_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  issue_valid,
    input logic [1:0]            issue_kind,
    input logic                  stall,
    input logic                  mem_req_valid,
    input logic                  pend_q,
    input logic                  pend_sync,
    input logic                  pend_drained,
    input logic [2:0][CNT_W-1:0] ld_cnt,
    input logic [2:0][CNT_W-1:0] st_cnt
);
    localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

    AST_REQ_NOT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !stall);  // R2

    AST_REQ_ONLY_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (issue_valid && !issue_kind[1]));  // R4

    AST_COMPLETION_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && pend_sync && !pend_drained) |-> stall);  // R10

    AST_IDLE_BARRIER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_kind[1] && !pend_q && (ld_cnt == '0) && (st_cnt == '0))
        |-> !stall);  // R11

    for (genvar d = 0; d < 3; d++) begin : g_wrap
        AST_NO_OVERFLOW_LD: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(ld_cnt[d]) == MAXC) |-> (ld_cnt[d] != '0));  // R3
        AST_NO_OVERFLOW_ST: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(st_cnt[d]) == MAXC) |-> (st_cnt[d] != '0));  // R3
    end

endmodule

bind mem_barrier_gate mbg_checker #(.CNT_W(CNT_W)) u_mbg_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue_valid   (issue_valid),
    .issue_kind    (issue_kind),
    .stall         (stall),
    .mem_req_valid (mem_req_valid),
    .pend_q        (pend_q),
    .pend_sync     (pend_rule_q.gate_all),
    .pend_drained  (pend_drained),
    .ld_cnt        (ld_cnt),
    .st_cnt        (st_cnt)
);

// File: tb/mem_barrier_gate_test.sv
// Bench: behavioural reference model of the barrier gate, compared every cycle.
module mem_barrier_gate_test;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 4;
    localparam int MAXC   = 15;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              issue_valid = 1'b0;
    logic [1:0]        issue_kind = '0;
    logic [1:0]        issue_dom = '0;
    logic [1:0]        issue_btype = '0;
    logic              issue_sync = 1'b0;
    logic [ADDR_W-1:0] issue_addr = '0;
    logic              ack_ld_valid = 1'b0;
    logic [1:0]        ack_ld_dom = '0;
    logic              ack_st_valid = 1'b0;
    logic [1:0]        ack_st_dom = '0;
    logic              stall;
    logic              mem_req_valid;
    logic              mem_req_store;
    logic [1:0]        mem_req_dom;
    logic [ADDR_W-1:0] mem_req_addr;

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";

    // Reference model state.
    int ld_out[3];
    int st_out[3];
    bit m_pend, m_sync, m_wl, m_ws, m_gl, m_gs;
    int m_lvl;

    always #10 clk = ~clk;

    mem_barrier_gate #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_kind(issue_kind),
        .issue_dom(issue_dom), .issue_btype(issue_btype), .issue_sync(issue_sync),
        .issue_addr(issue_addr), .ack_ld_valid(ack_ld_valid), .ack_ld_dom(ack_ld_dom),
        .ack_st_valid(ack_st_valid), .ack_st_dom(ack_st_dom), .stall(stall),
        .mem_req_valid(mem_req_valid), .mem_req_store(mem_req_store),
        .mem_req_dom(mem_req_dom), .mem_req_addr(mem_req_addr)
    );

    function automatic int lvl_of(input logic [1:0] c);
        return (c == 2'b11) ? 2 : int'(c);
    endfunction

    function automatic bit model_empty(input bit wl, input bit ws, input int lv);
        for (int i = 0; i <= lv; i++) begin
            if ((wl && ld_out[i] != 0) || (ws && st_out[i] != 0)) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic check_bit(input string what, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s got %0b exp %0b at %0t", tag, what, got, exp, $time);
        end
    endtask

    // One clock: inputs already set; compare at mid-cycle, advance the model.
    task automatic cyc();
        int  lv, al, sl;
        bit  isl, ist, isb, blk, e_stall, e_req, nwl, nws, ngl, ngs;
        #2;
        lv  = lvl_of(issue_dom);
        isl = issue_valid && issue_kind == 2'b00;
        ist = issue_valid && issue_kind == 2'b01;
        isb = issue_valid && issue_kind[1];
        blk = m_pend && !model_empty(m_wl, m_ws, m_lvl);
        e_stall = (blk && m_sync) || (blk && ((isl && m_gl) || (ist && m_gs) || isb)) ||
                  (isl && ld_out[lv] == MAXC) || (ist && st_out[lv] == MAXC);
        e_req = (isl || ist) && !e_stall;
        check_bit("stall", stall, e_stall);
        check_bit("mem_req_valid", mem_req_valid, e_req);
        if (e_req) begin
            check_bit("mem_req_store", mem_req_store, ist);
            n_cmp++;
            if (mem_req_addr !== issue_addr || mem_req_dom !== issue_dom) begin
                n_bad++;
                $display("FAIL %s req fields got %h/%0d exp %h/%0d", tag,
                         mem_req_addr, mem_req_dom, issue_addr, issue_dom);
            end
        end
        // Pending barrier update, from counts before this edge.
        if (isb && !e_stall) begin
            nwl = (issue_btype != 2'b10);
            nws = (issue_btype != 2'b01);
            ngl = (issue_btype != 2'b10);
            ngs = 1'b1;
            m_pend = !model_empty(nwl, nws, lv);
            m_sync = issue_sync;
            m_wl = nwl; m_ws = nws; m_gl = ngl; m_gs = ngs; m_lvl = lv;
        end else if (!blk) begin
            m_pend = 1'b0;
        end
        // Counter update: decrement decided on the old value.
        al = lvl_of(ack_ld_dom);
        sl = lvl_of(ack_st_dom);
        begin
            bit dl, ds;
            dl = ack_ld_valid && ld_out[al] > 0;
            ds = ack_st_valid && st_out[sl] > 0;
            if (e_req && isl) ld_out[lv]++;
            if (e_req && ist) st_out[lv]++;
            if (dl) ld_out[al]--;
            if (ds) st_out[sl]--;
        end
        @(negedge clk);
    endtask

    task automatic set_idle();
        issue_valid = 1'b0; ack_ld_valid = 1'b0; ack_st_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            set_idle();
            cyc();
        end
    endtask

    task automatic acc(input bit st, input logic [1:0] d, input logic [31:0] a);
        set_idle();
        issue_valid = 1'b1; issue_kind = st ? 2'b01 : 2'b00; issue_dom = d; issue_addr = a;
        cyc();
    endtask

    task automatic bar(input logic [1:0] d, input logic [1:0] bt, input bit sy);
        set_idle();
        issue_valid = 1'b1; issue_kind = 2'b10; issue_dom = d;
        issue_btype = bt; issue_sync = sy;
        cyc();
    endtask

    task automatic ack(input bit st, input logic [1:0] d);
        set_idle();
        if (st) begin ack_st_valid = 1'b1; ack_st_dom = d; end
        else    begin ack_ld_valid = 1'b1; ack_ld_dom = d; end
        cyc();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        foreach (ld_out[i]) begin ld_out[i] = 0; st_out[i] = 0; end
        m_pend = 0; m_sync = 0; m_wl = 0; m_ws = 0; m_gl = 0; m_gs = 0; m_lvl = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        tag = "R1";  idle(3);
        tag = "R11"; bar(2'b10, 2'b00, 1'b1); acc(0, 2'b00, 32'h100); ack(0, 2'b00);

        tag = "R2";  acc(0, 2'b00, 32'hA000); acc(1, 2'b01, 32'hB004);
        tag = "R4";  acc(1, 2'b11, 32'hC008); acc(0, 2'b10, 32'hD00C);
        ack(0, 2'b00); ack(0, 2'b10); ack(1, 2'b01); ack(1, 2'b11);

        tag = "R5";  acc(0, 2'b00, 32'h10); bar(2'b00, 2'b00, 1'b0);
        acc(1, 2'b00, 32'h14); acc(0, 2'b00, 32'h18);
        tag = "R9";  bar(2'b00, 2'b01, 1'b0); ack(0, 2'b00);
        acc(1, 2'b00, 32'h14); ack(1, 2'b00);

        tag = "R6";  acc(1, 2'b00, 32'h20); bar(2'b00, 2'b01, 1'b0);
        acc(0, 2'b00, 32'h24); ack(0, 2'b00); ack(1, 2'b00);
        acc(0, 2'b00, 32'h28); bar(2'b00, 2'b01, 1'b0); acc(1, 2'b00, 32'h2C);
        ack(0, 2'b00); acc(1, 2'b00, 32'h2C); ack(1, 2'b00);

        tag = "R7";  acc(1, 2'b00, 32'h30); bar(2'b00, 2'b10, 1'b0);
        acc(0, 2'b00, 32'h34); acc(1, 2'b00, 32'h38); bar(2'b00, 2'b00, 1'b0);
        ack(1, 2'b00); acc(1, 2'b00, 32'h38); ack(0, 2'b00); ack(1, 2'b00);

        tag = "R8";  acc(1, 2'b01, 32'h40); bar(2'b00, 2'b00, 1'b0);
        acc(1, 2'b00, 32'h44); ack(1, 2'b00);
        bar(2'b10, 2'b00, 1'b0); acc(0, 2'b00, 32'h48); ack(1, 2'b01);
        acc(0, 2'b00, 32'h48); ack(0, 2'b00);

        tag = "R10"; acc(0, 2'b01, 32'h50); bar(2'b01, 2'b00, 1'b1);
        idle(3); acc(1, 2'b10, 32'h54); ack(0, 2'b01); acc(1, 2'b10, 32'h54);
        ack(1, 2'b10);

        tag = "R3";  ack(0, 2'b00); acc(0, 2'b00, 32'h60);
        bar(2'b00, 2'b01, 1'b1); ack(0, 2'b00); idle(1);
        for (int i = 0; i < 16; i++) acc(0, 2'b00, 32'h100 + 32'(i));
        acc(0, 2'b01, 32'h200); ack(0, 2'b01);
        for (int i = 0; i < 15; i++) ack(0, 2'b00);
        idle(2);

        // Random traffic against the model.
        tag = "R9";
        for (int i = 0; i < 1500; i++) begin
            tag = (i % 2 == 0) ? "R9" : "R10";
            issue_valid  = $urandom_range(0, 3) != 0;
            issue_kind   = 2'($urandom_range(0, 3));
            issue_dom    = 2'($urandom_range(0, 3));
            issue_btype  = 2'($urandom_range(0, 3));
            issue_sync   = $urandom_range(0, 3) == 0;
            issue_addr   = $urandom;
            ack_ld_valid = $urandom_range(0, 1) == 1;
            ack_ld_dom   = 2'($urandom_range(0, 3));
            ack_st_valid = $urandom_range(0, 1) == 1;
            ack_st_dom   = 2'($urandom_range(0, 3));
            cyc();
        end
        idle(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule